// File: doc/BRIEF.md
# Eight-Channel ADC Scan Sequencer

This block drives a serial ADC that has separate data-in and data-out lines. After one start request it walks through all eight analog channels with no further help from a processor. Each serial frame carries two words at once. The host shifts out the configuration word for the next channel and shifts in the result of the channel that was just converted. Between frames the block pulses a conversion-start line. It then waits for the conversion to end, either by watching the converter's busy line or by counting a fixed number of system clocks. A parameter picks between the two.

The scan takes nine frames and eight conversions. The first frame only loads the configuration for channel 0, and the word it reads back is thrown away. Each later frame reads the result of the channel converted before it. Each result is stored in an eight-entry result memory at that channel's own address, and the memory has an asynchronous read port. The last frame writes an all-zero word, so the converter's configuration is left as it was. When the eighth result is stored, a done flag is raised.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is asserted, and right after it, `cs_n_o` and `sclk_o` are high, and `convst_o`, `mosi_o` and `done_o` are low.
- R2: Every frame holds `cs_n_o` low for exactly 16 rising edges of `sclk_o`. `sclk_o` is high whenever `cs_n_o` is high. The host changes `mosi_o` only on falling edges of `sclk_o` and samples `miso_i` on rising edges (clock polarity 1, phase 1).
- R3: Both words are shifted most significant bit first, in the same frame, one bit each way per SCLK period.
- R4: The frame with index k in a scan (k = 0..7) sends a configuration word with bit 15 = 1, bits 2..0 = k and every other bit 0. Frame 8 sends 16'h0000.
- R5: A scan has exactly 9 frames and 8 conversion-start pulses, in the order frame, pulse, wait, frame. Each pulse on `convst_o` lasts one system clock and is issued only while `cs_n_o` is high, after the preceding frame has ended.
- R6: When `WAIT_ON_BUSY` = 1, the next frame does not begin until `busy_i` has gone low after the pulse. `busy_i` passes through a two-stage synchronizer first.
- R7: When `WAIT_ON_BUSY` = 0, the next frame begins at least `CONV_CYCLES` clocks after the pulse, and `busy_i` has no effect.
- R8: The word read in frame k (k = 1..8) is stored at result address k-1 and can be read through `rd_addr_i`/`rd_data_o`.
- R9: `done_o` rises in the cycle after the eighth result is stored. It stays high until a new start is accepted, and it goes low in the cycle after that start is accepted.
- R10: A start request made while a scan is running is ignored. The scan still has exactly 9 frames and 8 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin an eight-channel scan |
| done_o | output | 1 | All eight results are stored |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_n_o | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |
| convst_o | output | 1 | One-clock conversion-start pulse |
| busy_i | input | 1 | Converter busy, asynchronous |
| rd_addr_i | input | 3 | Result memory read address |
| rd_data_o | output | 16 | Result memory read data |

## Verification
Two things are hard to reach from the ports. The first is a start request that arrives in the middle of a scan. The second is the timeout variant running against a busy line that never falls. The bench creates both situations. It drives a second start pulse several hundred cycles into each scan. It also runs a second instance in timeout mode, whose converter model holds busy permanently high. In the busy-wait instance, the conversion time changes with the channel, so a sequencer that ignored busy would open a frame during a conversion, and the model reports that.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FRAME = 3'd1,
    ST_PULSE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } scan_state_e;

endpackage

// File: rtl/spi3_frame_eng.sv
module spi3_frame_eng #(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);

  localparam int EDGE_N = 2 * WORD_W;
  localparam int EW     = $clog2(EDGE_N + 1);
  localparam int DW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic              active_q, active_d;
  logic [DW-1:0]     div_q, div_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              sclk_q, sclk_d;
  logic              cs_n_q, cs_n_d;
  logic              mosi_q, mosi_d;
  logic              done_q, done_d;
  logic              tick;

  assign tick = active_q && (div_q == DW'(HALF_DIV - 1));

  always_comb begin
    active_d = active_q;
    div_d    = div_q;
    edge_d   = edge_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    word_d   = word_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    mosi_d   = mosi_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (launch_i) begin
        active_d = 1'b1;
        cs_n_d   = 1'b0;
        div_d    = '0;
        edge_d   = '0;
        tx_d     = tx_word_i;
      end
    end else begin
      div_d = tick ? '0 : div_q + DW'(1);
      if (tick) begin
        if (edge_q == EW'(EDGE_N)) begin
          active_d = 1'b0;
          cs_n_d   = 1'b1;
          mosi_d   = 1'b0;
          done_d   = 1'b1;
          word_d   = rx_q;
        end else if (!edge_q[0]) begin
          sclk_d = 1'b0;
          mosi_d = tx_q[WORD_W-1];
          tx_d   = {tx_q[WORD_W-2:0], 1'b0};
          edge_d = edge_q + EW'(1);
        end else begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[WORD_W-2:0], miso_i};
          edge_d = edge_q + EW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      word_q   <= '0;
      sclk_q   <= 1'b1;
      cs_n_q   <= 1'b1;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      div_q    <= div_d;
      edge_q   <= edge_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      word_q   <= word_d;
      sclk_q   <= sclk_d;
      cs_n_q   <= cs_n_d;
      mosi_q   <= mosi_d;
      done_q   <= done_d;
    end
  end

  assign sclk_o    = sclk_q;
  assign cs_n_o    = cs_n_q;
  assign mosi_o    = mosi_q;
  assign done_o    = done_q;
  assign rx_word_o = word_q;

  // R2
  sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R2
  cs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(launch_i));

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !$fell(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/conv_waiter.sv
module conv_waiter #(
  parameter int WAIT_ON_BUSY = 1,
  parameter int CONV_CYCLES  = 600,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic busy_i,
  output logic fire_o
);

  localparam int GUARD = SYNC_STAGES + 2;
  localparam int LIMIT = (CONV_CYCLES > GUARD) ? CONV_CYCLES : GUARD;
  localparam int CW    = $clog2(LIMIT + 1);

  logic          wait_q, wait_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire;

  generate
    if (WAIT_ON_BUSY != 0) begin : g_busy
      logic [SYNC_STAGES-1:0] sync_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], busy_i};
      end

      assign fire = wait_q && (cnt_q >= CW'(GUARD)) && !sync_q[SYNC_STAGES-1];

      // R6
      busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !$past(busy_i, SYNC_STAGES));
    end else begin : g_timer
      assign fire = wait_q && (cnt_q == CW'(CONV_CYCLES - 1));
    end
  endgenerate

  always_comb begin
    wait_d = wait_q;
    cnt_d  = cnt_q;
    if (arm_i) begin
      wait_d = 1'b1;
      cnt_d  = '0;
    end else if (fire) begin
      wait_d = 1'b0;
    end else if (wait_q && (cnt_q != CW'(LIMIT))) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  assign fire_o = fire;

endmodule

// File: rtl/scan_result_mem.sv
module scan_result_mem #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [WORD_W-1:0]        rd_data_o
);

  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] cell_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cell_q[i] <= '0;
        else if (hit) cell_q[i] <= wr_data_i;
      end
    end
  endgenerate

  assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import scan_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int WORD_W       = 16,
  parameter int SCLK_HALF    = 2,
  parameter int WAIT_ON_BUSY = 1,
  parameter int CONV_CYCLES  = 600
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic                      done_o,
  output logic                      sclk_o,
  output logic                      cs_n_o,
  output logic                      mosi_o,
  input  logic                      miso_i,
  output logic                      convst_o,
  input  logic                      busy_i,
  input  logic [$clog2(NUM_CH)-1:0] rd_addr_i,
  output logic [WORD_W-1:0]         rd_data_o
);

  localparam int CH_W = $clog2(NUM_CH);
  localparam int KW   = $clog2(NUM_CH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  scan_state_e       state_q, state_d;
  logic [KW-1:0]     k_q, k_d;
  logic              done_q, done_d;
  logic              convst_q;
  logic              launch;
  logic [KW-1:0]     launch_k;
  logic [WORD_W-1:0] cfg_word;
  logic              f_done;
  logic [WORD_W-1:0] f_rx;
  logic              fire;
  logic              mem_we;
  logic [CH_W-1:0]   mem_addr;

  // index of the frame about to open
  always_comb begin
    launch_k = (state_q == ST_WAIT) ? k_q + KW'(1) : '0;
    cfg_word = '0;
    if (launch_k < KW'(NUM_CH)) begin
      cfg_word[WORD_W-1] = 1'b1;
      cfg_word[CH_W-1:0] = launch_k[CH_W-1:0];
    end
  end

  always_comb begin
    state_d  = state_q;
    k_d      = k_q;
    done_d   = done_q;
    launch   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = CH_W'(k_q - KW'(1));
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          k_d     = '0;
          done_d  = 1'b0;
          launch  = 1'b1;
          state_d = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (f_done) begin
          mem_we = (k_q != '0);
          if (k_q == KW'(NUM_CH)) begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_PULSE;
          end
        end
      end
      ST_PULSE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (fire) begin
          k_d     = k_q + KW'(1);
          launch  = 1'b1;
          state_d = ST_FRAME;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_IDLE;
      k_q      <= '0;
      done_q   <= 1'b0;
      convst_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      k_q      <= k_d;
      done_q   <= done_d;
      convst_q <= (state_d == ST_PULSE);
    end
  end

  spi3_frame_eng #(
    .WORD_W  (WORD_W),
    .HALF_DIV(SCLK_HALF)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .launch_i (launch),
    .tx_word_i(cfg_word),
    .miso_i   (miso_i),
    .sclk_o   (sclk_o),
    .cs_n_o   (cs_n_o),
    .mosi_o   (mosi_o),
    .done_o   (f_done),
    .rx_word_o(f_rx)
  );

  conv_waiter #(
    .WAIT_ON_BUSY(WAIT_ON_BUSY),
    .CONV_CYCLES (CONV_CYCLES),
    .SYNC_STAGES (2)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n_s),
    .arm_i (state_q == ST_PULSE),
    .busy_i(busy_i),
    .fire_o(fire)
  );

  scan_result_mem #(
    .DEPTH (NUM_CH),
    .WORD_W(WORD_W)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en_i  (mem_we),
    .wr_addr_i(mem_addr),
    .wr_data_i(f_rx),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  assign done_o   = done_q;
  assign convst_o = convst_q;

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    convst_o |=> !convst_o);

  // R5
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    convst_o |-> cs_n_o);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(done_o) |-> $past(mem_we && (mem_addr == CH_W'(NUM_CH - 1))));

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(done_o) |-> $past(start_i));

  // R10
  scan_locked_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && (state_q == ST_PULSE)) |=> (state_q == ST_WAIT));

endmodule

// File: tb/adc_scan_seq_tb_top.sv
module scan_adc_model #(
  parameter int CONV_T     = 30,
  parameter int BUSY_STUCK = 0,
  parameter int MIN_GAP    = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  input  logic convst,
  output logic miso,
  output logic busy
);
  logic        sclk_p, cs_p, convst_p;
  logic [15:0] rx, tx, res_hold;
  logic [2:0]  cfg_ch, conv_ch;
  bit          conv_act;
  int          conv_left, gap, bits, scan_no;
  int          frame_cnt, convst_cnt, n_chk, n_err;
  logic [15:0] log_w [0:31];
  logic [15:0] exp_res [0:7];

  function automatic logic [15:0] res_fn(input logic [2:0] ch, input int scan);
    res_fn = (16'(ch) * 16'h0911) ^ (16'(scan + 1) * 16'h3C5A) ^ 16'h8001;
  endfunction

  task automatic bad(input string req, input int act, input int exp);
    n_err++;
    $display("FAIL %s model: actual=%0d expected=%0d t=%0t", req, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      sclk_p = 1; cs_p = 1; convst_p = 0; miso = 0;
      busy = (BUSY_STUCK != 0); conv_act = 0; gap = 1000000;
      bits = 0; cfg_ch = 0; conv_ch = 0; res_hold = 0; rx = 0; tx = 0;
      frame_cnt = 0; convst_cnt = 0; scan_no = 0; conv_left = 0;
      n_chk = 0; n_err = 0;
    end else begin
      // R2 clock parks high outside a frame
      n_chk++;
      if (cs_n && !sclk) bad("R2 sclk idle", int'(sclk), 1);
      if (convst) begin
        // R5 single-clock pulse, only between frames, not during a conversion
        n_chk++;
        if (convst_p || !cs_n || conv_act) bad("R5 convst", int'(convst_p) + 2*int'(!cs_n), 0);
        convst_cnt++;
        conv_act  = 1;
        conv_ch   = cfg_ch;
        conv_left = CONV_T + 3 * int'(cfg_ch);
        gap       = 0;
      end else begin
        gap++;
        if (conv_act) begin
          conv_left--;
          if (conv_left == 0) begin
            conv_act = 0;
            res_hold = res_fn(conv_ch, scan_no);
            exp_res[conv_ch] = res_hold;
          end
        end
      end
      busy = (BUSY_STUCK != 0) ? 1'b1 : conv_act;
      if (cs_p && !cs_n) begin
        n_chk++;
        // R6 frame never opens while converting; R7 minimum gap after a pulse
        if (conv_act) bad("R6 frame during conversion", 1, 0);
        if (gap < MIN_GAP) bad("R7 gap", gap, MIN_GAP);
        tx = res_hold; bits = 0;
      end
      if (!cs_n && sclk_p && !sclk) begin
        miso = tx[15];
        tx = {tx[14:0], 1'b0};
      end
      if (!cs_n && !sclk_p && sclk) begin
        rx = {rx[14:0], mosi};
        bits++;
      end
      if (!cs_p && cs_n) begin
        n_chk++;
        if (bits != 16) bad("R2 bits per frame", bits, 16);
        if (frame_cnt < 32) log_w[frame_cnt] = rx;
        frame_cnt++;
        if (rx[15]) cfg_ch = rx[2:0];
        else        scan_no++;
      end
      sclk_p = sclk; cs_p = cs_n; convst_p = convst;
    end
  end
endmodule

module adc_scan_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  rd_addr;
  logic        done_b, sclk_b, cs_b, mosi_b, miso_b, conv_b, busy_b;
  logic        done_t, sclk_t, cs_t, mosi_t, miso_t, conv_t, busy_t;
  logic [15:0] rd_b, rd_t;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done_b),
    .sclk_o(sclk_b), .cs_n_o(cs_b), .mosi_o(mosi_b), .miso_i(miso_b),
    .convst_o(conv_b), .busy_i(busy_b), .rd_addr_i(rd_addr), .rd_data_o(rd_b)
  );

  adc_scan_seq #(.WAIT_ON_BUSY(0), .CONV_CYCLES(60)) dut_t (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done_t),
    .sclk_o(sclk_t), .cs_n_o(cs_t), .mosi_o(mosi_t), .miso_i(miso_t),
    .convst_o(conv_t), .busy_i(busy_t), .rd_addr_i(rd_addr), .rd_data_o(rd_t)
  );

  scan_adc_model #(.CONV_T(30), .BUSY_STUCK(0), .MIN_GAP(0)) m_b (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_b), .cs_n(cs_b), .mosi(mosi_b),
    .convst(conv_b), .miso(miso_b), .busy(busy_b)
  );

  scan_adc_model #(.CONV_T(20), .BUSY_STUCK(1), .MIN_GAP(60)) m_t (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_t), .cs_n(cs_t), .mosi(mosi_t),
    .convst(conv_t), .miso(miso_t), .busy(busy_t)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==",
             n_vec + m_b.n_chk + m_t.n_chk, n_bad + m_b.n_err + m_t.n_err);
  endtask

  // every-clock comparison against the protocol model's expectations
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(!(conv_b && !cs_b) && !(conv_t && !cs_t), "R5 strobe outside frame",
          {conv_b, cs_b, conv_t, cs_t}, 32'h5);
    end
  end

  task automatic check_scan(input int scan);
    for (int k = 0; k < 9; k++) begin
      logic [15:0] e;
      e = (k < 8) ? (16'h8000 | 16'(k)) : 16'h0000;
      chk(m_b.log_w[scan*9+k] == e, "R4 R3 config word busy-mode", m_b.log_w[scan*9+k], e);
      chk(m_t.log_w[scan*9+k] == e, "R4 R3 config word timeout-mode", m_t.log_w[scan*9+k], e);
    end
    chk(m_b.frame_cnt == 9*(scan+1), "R5 R10 frame count", m_b.frame_cnt, 9*(scan+1));
    chk(m_t.frame_cnt == 9*(scan+1), "R5 R10 frame count t", m_t.frame_cnt, 9*(scan+1));
    chk(m_b.convst_cnt == 8*(scan+1), "R5 pulse count", m_b.convst_cnt, 8*(scan+1));
    chk(m_t.convst_cnt == 8*(scan+1), "R5 R7 pulse count t", m_t.convst_cnt, 8*(scan+1));
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) rd_addr = 3'(c);
      #1;
      chk(rd_b == m_b.exp_res[c], "R8 stored result", rd_b, m_b.exp_res[c]);
      chk(rd_t == m_t.exp_res[c], "R8 R7 stored result t", rd_t, m_t.exp_res[c]);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_addr = '0;
    repeat (5) @(negedge clk);
    // R1 outputs while reset is held
    chk(cs_b && sclk_b && !conv_b && !mosi_b && !done_b, "R1 reset busy-mode",
        {cs_b, sclk_b, conv_b, mosi_b, done_b}, 32'h18);
    chk(cs_t && sclk_t && !conv_t && !mosi_t && !done_t, "R1 reset timeout-mode",
        {cs_t, sclk_t, conv_t, mosi_t, done_t}, 32'h18);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_b && sclk_b && !done_b && !conv_b, "R1 after release", {cs_b, sclk_b, done_b, conv_b}, 32'hC);

    for (int scan = 0; scan < 2; scan++) begin
      pulse_start();
      @(negedge clk);
      // R9 done cleared once start is taken
      chk(!done_b && !done_t, "R9 done cleared", {done_b, done_t}, 0);
      repeat (300) @(negedge clk);
      pulse_start(); // R10 ignored mid-scan
      repeat (200) @(negedge clk);
      pulse_start(); // R10 ignored mid-scan again
      chk(!done_b && !done_t, "R10 no early done", {done_b, done_t}, 0);
      while (!(done_b && done_t)) @(negedge clk);
      check_scan(scan);
      repeat (20) @(negedge clk);
      // R9 done holds, line stays idle
      chk(done_b && done_t && cs_b && cs_t, "R9 done holds", {done_b, done_t, cs_b, cs_t}, 32'hF);
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule